// File: doc/BRIEF.md
# Signed BCD Adder/Subtracter

This block adds or subtracts two signed decimal numbers. Each number is held as packed BCD digits with a separate sign bit, in sign-magnitude form. A single control line chooses between sum and difference. The result comes back in the same form: a BCD magnitude, a sign and an overflow flag.

Internally each operand gets one extra sign decade that holds 0 or 9. An operand whose effective sign is negative is nine's-complemented across all of its decades. Operand A's effective sign is its own sign bit. Operand B's effective sign is the XOR of its sign bit and the subtract line. A ripple chain of decimal digit adders forms the sum. Each digit adder does a binary add and then corrects any total of ten or more back into a BCD digit with a carry. The carry out of the sign decade is fed back as an end-around carry. The final sign decade gives the result sign and shows whether the magnitude overflowed. A negative raw result is complemented once more to give its magnitude.

The number of decades is set by a parameter. The result can be taken straight from the logic, or through one output register.

Top module: `bcd_signed_addsub`

## Requirements
- R1: `res_mag` is packed BCD with the units digit in bits [3:0] and decade i in bits [4i+3:4i]. Every output digit is in the range 0 to 9.
- R2: Sign bits use 0 for positive and 1 for negative, on both operands and on the result. `sub`=0 selects A+B and `sub`=1 selects A−B.
- R3: When the magnitude of the signed result is below 10^DIGITS, `res_mag` equals that magnitude, `res_neg` gives its sign and `ovf` is 0.
- R4: A decimal carry out of any decade reaches the next decade up, through a run of any length of decades that sum to 9. For example, 0999+0001 gives 1000.
- R5: Subtracting a negative B gives the same result as adding its magnitude.
- R6: When the effective signs differ (`a_neg` differs from `sub` XOR `b_neg`), `ovf` is 0. The magnitude is the difference of the two magnitudes, and the sign is the sign of the operand with the larger magnitude.
- R7: When the effective signs are equal and the sum of the magnitudes reaches 10^DIGITS, `ovf` is 1. `res_mag` is that sum modulo 10^DIGITS and `res_neg` is the common sign.
- R8: A zero magnitude without overflow is always reported as positive. This covers A−A and inputs given as negative zero.
- R9: With REG_OUT=1, results appear on the clock edge after the inputs. While `rst_n` is low, the outputs are held at zero, positive and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset for the output register |
| a_mag | input | 4*DIGITS | Magnitude of A, packed BCD |
| a_neg | input | 1 | Sign of A (1 = negative) |
| b_mag | input | 4*DIGITS | Magnitude of B, packed BCD |
| b_neg | input | 1 | Sign of B (1 = negative) |
| sub | input | 1 | 0 = add, 1 = subtract |
| res_mag | output | 4*DIGITS | Result magnitude, packed BCD |
| res_neg | output | 1 | Result sign |
| ovf | output | 1 | Magnitude exceeded DIGITS decades |

## Verification
With the default REG_OUT=1, every result is due on the first rising edge after its operands are applied. The bench drives operands on the falling edge and waits for the next rising edge. It reads the outputs 1 ns after that edge, so each check sees the registered result of exactly one stimulus. An integer model in the bench computes the signed sum or difference, its magnitude, the overflow and the zero-sign rule. The model is checked on directed carry and boundary cases and on random operands under all eight sign and mode combinations.

// File: rtl/bcd_signed_addsub.sv
module bcd_signed_addsub #(
  parameter int DIGITS  = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*DIGITS-1:0]   a_mag,
  input  logic                  a_neg,
  input  logic [4*DIGITS-1:0]   b_mag,
  input  logic                  b_neg,
  input  logic                  sub,
  output logic [4*DIGITS-1:0]   res_mag,
  output logic                  res_neg,
  output logic                  ovf
);
  localparam int W  = 4*DIGITS;
  localparam int WX = 4*(DIGITS+1);

  function automatic logic [W-1:0] nines(input logic [W-1:0] v);
    logic [W-1:0] n;
    for (int i = 0; i < DIGITS; i++) n[4*i +: 4] = 4'd9 - v[4*i +: 4];
    return n;
  endfunction

  function automatic logic [4:0] dec_add(input logic [3:0] x, input logic [3:0] y, input logic ci);
    logic [4:0] raw;
    raw = {1'b0, x} + {1'b0, y} + {4'd0, ci};
    if (raw > 5'd9) return {1'b1, raw[3:0] - 4'd10};
    return raw;
  endfunction

  logic          b_eff;
  logic [WX-1:0] ax, bx, s1, s2;
  logic          c1;
  logic [3:0]    top;
  logic [W-1:0]  mag_d;
  logic          neg_raw, neg_d, ovf_d;

  assign b_eff = sub ^ b_neg;
  assign ax = {a_neg ? 4'd9 : 4'd0, a_neg ? nines(a_mag) : a_mag};
  assign bx = {b_eff ? 4'd9 : 4'd0, b_eff ? nines(b_mag) : b_mag};

  always_comb begin
    logic       c;
    logic [4:0] d;
    c = 1'b0;
    for (int i = 0; i <= DIGITS; i++) begin
      d = dec_add(ax[4*i +: 4], bx[4*i +: 4], c);
      s1[4*i +: 4] = d[3:0];
      c = d[4];
    end
    c1 = c;
    for (int i = 0; i <= DIGITS; i++) begin
      d = dec_add(s1[4*i +: 4], 4'd0, c);
      s2[4*i +: 4] = d[3:0];
      c = d[4];
    end
  end

  assign top     = s2[WX-1 -: 4];
  assign neg_raw = (top == 4'd9) || (top == 4'd8);
  assign ovf_d   = (top == 4'd1) || (top == 4'd8);
  assign mag_d   = neg_raw ? nines(s2[W-1:0]) : s2[W-1:0];
  assign neg_d   = neg_raw && !(mag_d == '0 && !ovf_d);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_mag <= '0;
          res_neg <= 1'b0;
          ovf     <= 1'b0;
        end else begin
          res_mag <= mag_d;
          res_neg <= neg_d;
          ovf     <= ovf_d;
        end
      end
    end else begin : g_comb
      assign res_mag = mag_d;
      assign res_neg = neg_d;
      assign ovf     = ovf_d;
    end
  endgenerate

  for (genvar g = 0; g < DIGITS; g++) begin : g_chk
    a_r1_digit_valid: assert property (@(posedge clk) disable iff (!rst_n)
      res_mag[4*g +: 4] <= 4'd9);
  end

  a_r6_mixed_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (a_neg != b_eff) |-> !ovf_d);

  a_r8_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_neg && !ovf) |-> (res_mag != '0));

  a_r8_self_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && a_mag == b_mag && a_neg == b_neg) |-> (mag_d == '0 && !neg_d && !ovf_d));

  a_r3_zero_in: assert property (@(posedge clk) disable iff (!rst_n)
    (a_mag == '0 && b_mag == '0) |-> (mag_d == '0 && !neg_d && !ovf_d));

  a_r7_ovf_sign: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_d |-> (neg_d == a_neg && a_neg == b_eff));
endmodule

// File: tb/sim_bcd_signed_addsub.sv
`timescale 1ns/1ps
module sim_bcd_signed_addsub;
  localparam int N = 4;
  localparam int LIM = 10000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4*N-1:0] a_mag = '0, b_mag = '0;
  logic a_neg = 1'b0, b_neg = 1'b0, sub = 1'b0;
  logic [4*N-1:0] res_mag;
  logic res_neg, ovf;
  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  bcd_signed_addsub #(.DIGITS(N), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .a_mag(a_mag), .a_neg(a_neg), .b_mag(b_mag),
    .b_neg(b_neg), .sub(sub), .res_mag(res_mag), .res_neg(res_neg), .ovf(ovf));

  function automatic logic [4*N-1:0] to_bcd(input int v);
    logic [4*N-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic step(input int a, input bit an, input int b, input bit bn, input bit s, input string tag);
    int va, vb, r, m;
    bit en, eo;
    logic [4*N-1:0] em;
    @(negedge clk);
    a_mag = to_bcd(a); a_neg = an; b_mag = to_bcd(b); b_neg = bn; sub = s;
    va = an ? -a : a;
    vb = bn ? -b : b;
    r  = s ? va - vb : va + vb;
    en = r < 0;
    m  = en ? -r : r;
    eo = m >= LIM;
    m  = m % LIM;
    if (m == 0 && !eo) en = 1'b0;
    em = to_bcd(m);
    @(posedge clk);
    #1;
    n_tests++;
    if (res_mag !== em || res_neg !== en || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s: %0s%0d %s %0s%0d got mag=%h neg=%b ovf=%b expected mag=%h neg=%b ovf=%b",
               tag, an ? "-" : "+", a, s ? "-" : "+", bn ? "-" : "+", b,
               res_mag, res_neg, ovf, em, en, eo);
    end
  endtask

  initial begin
    #(4*200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    a_mag = to_bcd(1234); b_mag = to_bcd(4321); a_neg = 1'b1;
    @(posedge clk); #1;
    n_tests++;
    if (res_mag !== '0 || res_neg !== 1'b0 || ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: reset got mag=%h neg=%b ovf=%b expected 0000/0/0", res_mag, res_neg, ovf);
    end
    @(negedge clk); rst_n = 1'b1;

    step(12, 0, 34, 0, 0, "R3 R2");
    step(999, 0, 1, 0, 0, "R4");
    step(9998, 0, 1, 0, 0, "R4 R1");
    step(5555, 0, 4444, 0, 0, "R3");
    step(250, 0, 17, 1, 1, "R5");
    step(9999, 1, 9999, 1, 1, "R5 R8");
    step(7, 0, 3, 1, 0, "R6");
    step(3, 0, 7, 1, 0, "R6");
    step(42, 1, 42, 1, 1, "R8");
    step(0, 1, 0, 0, 0, "R8");
    step(0, 1, 0, 1, 1, "R8");
    step(9999, 0, 1, 0, 0, "R7");
    step(5000, 1, 5000, 1, 0, "R7");
    step(9999, 1, 9999, 0, 1, "R7");
    step(6941, 0, 5870, 0, 0, "R7");
    step(1000, 0, 1, 0, 1, "R6 R4");
    step(0, 0, 1, 0, 1, "R2");

    for (int k = 0; k < 480; k++) begin
      automatic int sel = k % 8;
      step($urandom_range(0, LIM-1), sel[0], $urandom_range(0, LIM-1), sel[1], sel[2], "R3 R1");
    end
    for (int k = 0; k < 80; k++) begin
      automatic int x = $urandom_range(0, LIM-1);
      step(x, k[0], x, k[0], 1'b1, "R8");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule